// File: doc/BRIEF.md
# Key Change Reporter with Ghost Filter

This block takes one snapshot of a scanned key matrix at a time. A snapshot has up to eight slots, and each slot holds a valid bit, a row and a column. The block looks up each key's code in an internal table that software loads. It then compares the new key list with the set of keys it accepted last time. From that comparison it produces a stream of events on a valid/ready output: releases first, then presses, then a sync marker.

Some snapshots cannot be trusted because they show three or more keys arranged so that a phantom key could appear. The block rejects these silently. When the function-layer option is on, the function key is hidden from the output and the other keys in the same snapshot are looked up in a second table layer.

The controller is a single state machine with these states:
- ST_IDLE: waits for a snapshot.
- ST_SCAN: walks the eight slots, one per cycle, and compacts the valid keys into a list.
- ST_CHECK: applies the ghost rule.
- ST_XLATE: does the final keycode lookup.
- ST_REL: emits release events.
- ST_PRESS: emits press events.
- ST_SYNC: emits the sync marker and commits the new set.

The transitions are:
- ST_IDLE to ST_SCAN when a snapshot is accepted.
- ST_SCAN to ST_CHECK after the last slot.
- ST_CHECK to ST_IDLE when the snapshot is ghosted.
- ST_CHECK to ST_XLATE when it is not.
- ST_XLATE to ST_REL when the list is exhausted.
- ST_REL to ST_PRESS when the old set is exhausted.
- ST_PRESS to ST_SYNC when the new list is exhausted.
- ST_SYNC to ST_IDLE on the handshake of the sync event.

Top module: `keychg_reporter`

## Requirements
- R1: After reset, `snap_ready` is 1, `ev_valid` is 0 and the accepted key set is empty. Reset leaves the keycode table contents intact.
- R2: A snapshot is taken on a cycle where `snap_valid` and `snap_ready` are both 1. `snap_ready` then stays 0 until the stream for that snapshot has drained, or until a ghost rejection returns the block to idle.
- R3: A key's scancode is `row*8 + col`, which is the row shifted left 3 bits ORed with the column. The table address is `{layer, scancode}`, and a press event reports that 8-bit address in `ev_scan`.
- R4: With `tbl_we` high, the table entry at `tbl_addr` takes `tbl_data` at the clock edge. Later lookups return the new value.
- R5: With `fn_layer_en` high, any slot whose layer-0 keycode equals `FN_CODE` (default 16'h01D0) produces no event, and every other key is looked up at scancode + 128. With `fn_layer_en` low, that key is reported like any other key.
- R6: The ghost rule applies when three or more keys remain after the function key is removed. If some pair of them shares a row and some pair shares a column, the snapshot yields no events and no sync, and the accepted set is unchanged.
- R7: A release event is emitted for each accepted keycode that is absent from the new list, in accepted order. It has `ev_kind` = 0, `ev_scan` = 0 and `ev_code` set to that keycode.
- R8: A press event is emitted for every key in the new list, in slot order and after all releases. It has `ev_kind` = 1 and carries both the scancode and the keycode.
- R9: After the last release or press, one sync event is emitted with `ev_kind` = 2 and zero scan and code fields. On its handshake the new list becomes the accepted set.
- R10: With `snap_empty` high, the slot contents are ignored, every accepted key is released, and the set becomes empty.
- R11: While `ev_valid` is 1 and `ev_ready` is 0, the event stays valid and its kind, scan and code fields stay stable.
- R12: A slot whose valid bit is 0 contributes nothing, whatever its row and column hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fn_layer_en | input | 1 | Enables function-layer handling, sampled with the snapshot |
| snap_valid | input | 1 | Snapshot offered |
| snap_ready | output | 1 | Block can take a snapshot |
| snap_empty | input | 1 | Snapshot means "no keys down" |
| snap_key_vld | input | 8 | Valid bit per slot; slot i is bit i |
| snap_rows | input | 32 | Row per slot; slot i is bits 4i+3..4i |
| snap_cols | input | 24 | Column per slot; slot i is bits 3i+2..3i |
| tbl_we | input | 1 | Keycode table write enable |
| tbl_addr | input | 8 | Table write address `{layer, row, col}` |
| tbl_data | input | 16 | Table write data |
| ev_valid | output | 1 | Event available |
| ev_ready | input | 1 | Consumer takes the event |
| ev_kind | output | 2 | 0 release, 1 press, 2 sync |
| ev_scan | output | 8 | Table address of a pressed key |
| ev_code | output | 16 | Keycode of the event |

## Verification
The embedded properties watch, on every cycle:
- that output events stay stable under backpressure;
- that `snap_ready` drops after an accepted snapshot;
- that no release follows a press within one snapshot;
- that the layer bit of a pressed scancode tracks whether the function key was seen.

Only the bench scenarios can show the exact content and order of the event lists: set differences, the ghost patterns with and without the function key in the count, empty snapshots, table rewrites and the survival of the accepted set across a rejection.

// File: rtl/keychg_pkg.sv
package keychg_pkg;

    typedef enum logic [1:0] {
        EV_RELEASE = 2'd0,
        EV_PRESS   = 2'd1,
        EV_SYNC    = 2'd2
    } ev_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_CHECK,
        ST_XLATE,
        ST_REL,
        ST_PRESS,
        ST_SYNC
    } state_e;

endpackage

// File: rtl/keychg_keymap.sv
module keychg_keymap #(
    parameter int ADDR_W = 8,
    parameter int CODE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [CODE_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [CODE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [CODE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

    // R4: a table write must target a defined entry
    a_r4_write_addr_known: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> !$isunknown(waddr));

endmodule

// File: rtl/keychg_ghost.sv
module keychg_ghost #(
    parameter int SLOTS = 8,
    parameter int ROW_W = 4,
    parameter int COL_W = 3,
    parameter int CNT_W = 4
) (
    input  logic [ROW_W+COL_W-1:0] keys [SLOTS],
    input  logic [CNT_W-1:0]       count,
    output logic                   ghost
);
    localparam int SCAN_W = ROW_W + COL_W;

    logic share_row;
    logic share_col;

    always_comb begin
        share_row = 1'b0;
        share_col = 1'b0;
        for (int i = 0; i < SLOTS; i++) begin
            for (int j = i + 1; j < SLOTS; j++) begin
                if (CNT_W'(j) < count) begin
                    if (keys[i][SCAN_W-1:COL_W] == keys[j][SCAN_W-1:COL_W]) share_row = 1'b1;
                    if (keys[i][COL_W-1:0] == keys[j][COL_W-1:0]) share_col = 1'b1;
                end
            end
        end
        ghost = (count >= CNT_W'(3)) && share_row && share_col;
    end

endmodule

// File: rtl/keychg_reporter.sv
module keychg_reporter
    import keychg_pkg::*;
#(
    parameter int ROWS   = 16,
    parameter int COLS   = 8,
    parameter int SLOTS  = 8,
    parameter int CODE_W = 16,
    parameter logic [CODE_W-1:0] FN_CODE = 16'h01D0
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            fn_layer_en,
    input  logic                            snap_valid,
    output logic                            snap_ready,
    input  logic                            snap_empty,
    input  logic [SLOTS-1:0]                snap_key_vld,
    input  logic [SLOTS*$clog2(ROWS)-1:0]   snap_rows,
    input  logic [SLOTS*$clog2(COLS)-1:0]   snap_cols,
    input  logic                            tbl_we,
    input  logic [$clog2(ROWS)+$clog2(COLS):0] tbl_addr,
    input  logic [CODE_W-1:0]               tbl_data,
    output logic                            ev_valid,
    input  logic                            ev_ready,
    output logic [1:0]                      ev_kind,
    output logic [$clog2(ROWS)+$clog2(COLS):0] ev_scan,
    output logic [CODE_W-1:0]               ev_code
);
    localparam int ROW_W  = $clog2(ROWS);
    localparam int COL_W  = $clog2(COLS);
    localparam int SCAN_W = ROW_W + COL_W;
    localparam int ADDR_W = SCAN_W + 1;
    localparam int CNT_W  = $clog2(SLOTS + 1);
    localparam int IDX_W  = $clog2(SLOTS);

    state_e state_q, state_d;
    ev_kind_e kind;

    logic [CNT_W-1:0]         idx_q;
    logic [CNT_W-1:0]         new_n_q;
    logic [CNT_W-1:0]         old_n_q;
    logic                     fn_en_q;
    logic                     fn_hit_q;
    logic [SLOTS-1:0]         vld_q;
    logic [SLOTS*ROW_W-1:0]   rows_q;
    logic [SLOTS*COL_W-1:0]   cols_q;

    logic [SCAN_W-1:0]        new_scan_q [SLOTS];
    logic [ADDR_W-1:0]        new_addr_q [SLOTS];
    logic [CODE_W-1:0]        new_code_q [SLOTS];
    logic [CODE_W-1:0]        old_code_q [SLOTS];

    logic [ROW_W-1:0]         row_arr [SLOTS];
    logic [COL_W-1:0]         col_arr [SLOTS];

    logic [IDX_W-1:0]         idx_i;
    logic [IDX_W-1:0]         new_n_i;
    logic [ADDR_W-1:0]        lk_addr;
    logic [CODE_W-1:0]        lk_code;
    logic                     ghost;
    logic                     old_kept;

    assign idx_i   = idx_q[IDX_W-1:0];
    assign new_n_i = new_n_q[IDX_W-1:0];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        assign row_arr[g] = rows_q[g*ROW_W +: ROW_W];
        assign col_arr[g] = cols_q[g*COL_W +: COL_W];
    end

    // one read port shared by the slot walk and the layer translation
    always_comb begin
        lk_addr = {1'b0, row_arr[idx_i], col_arr[idx_i]};
        if (state_q == ST_XLATE) begin
            lk_addr = {fn_hit_q, new_scan_q[idx_i]};
        end
    end

    keychg_keymap #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_map (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tbl_we),
        .waddr (tbl_addr),
        .wdata (tbl_data),
        .raddr (lk_addr),
        .rdata (lk_code)
    );

    keychg_ghost #(.SLOTS(SLOTS), .ROW_W(ROW_W), .COL_W(COL_W), .CNT_W(CNT_W)) u_ghost (
        .keys  (new_scan_q),
        .count (new_n_q),
        .ghost (ghost)
    );

    always_comb begin
        old_kept = 1'b0;
        for (int k = 0; k < SLOTS; k++) begin
            if (CNT_W'(k) < new_n_q && new_code_q[k] == old_code_q[idx_i]) old_kept = 1'b1;
        end
    end

    // next state and outputs
    always_comb begin
        state_d    = state_q;
        snap_ready = 1'b0;
        ev_valid   = 1'b0;
        kind       = EV_SYNC;
        ev_scan    = '0;
        ev_code    = '0;
        unique case (state_q)
            ST_IDLE: begin
                snap_ready = 1'b1;
                if (snap_valid) state_d = ST_SCAN;
            end
            ST_SCAN: begin
                if (idx_q == CNT_W'(SLOTS - 1)) state_d = ST_CHECK;
            end
            ST_CHECK: begin
                state_d = ghost ? ST_IDLE : ST_XLATE;
            end
            ST_XLATE: begin
                if (idx_q >= new_n_q) state_d = ST_REL;
            end
            ST_REL: begin
                if (idx_q >= old_n_q) begin
                    state_d = ST_PRESS;
                end else if (!old_kept) begin
                    ev_valid = 1'b1;
                    kind     = EV_RELEASE;
                    ev_code  = old_code_q[idx_i];
                end
            end
            ST_PRESS: begin
                if (idx_q >= new_n_q) begin
                    state_d = ST_SYNC;
                end else begin
                    ev_valid = 1'b1;
                    kind     = EV_PRESS;
                    ev_scan  = new_addr_q[idx_i];
                    ev_code  = new_code_q[idx_i];
                end
            end
            ST_SYNC: begin
                ev_valid = 1'b1;
                kind     = EV_SYNC;
                if (ev_ready) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign ev_kind = kind;

    // state register and control counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            idx_q    <= '0;
            new_n_q  <= '0;
            old_n_q  <= '0;
            fn_en_q  <= 1'b0;
            fn_hit_q <= 1'b0;
            vld_q    <= '0;
            rows_q   <= '0;
            cols_q   <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: begin
                    if (snap_valid) begin
                        vld_q    <= snap_empty ? '0 : snap_key_vld;
                        rows_q   <= snap_rows;
                        cols_q   <= snap_cols;
                        fn_en_q  <= fn_layer_en;
                        fn_hit_q <= 1'b0;
                        new_n_q  <= '0;
                        idx_q    <= '0;
                    end
                end
                ST_SCAN: begin
                    if (vld_q[idx_i]) begin
                        if (fn_en_q && lk_code == FN_CODE) fn_hit_q <= 1'b1;
                        else new_n_q <= new_n_q + CNT_W'(1);
                    end
                    idx_q <= (idx_q == CNT_W'(SLOTS - 1)) ? '0 : idx_q + CNT_W'(1);
                end
                ST_CHECK: idx_q <= '0;
                ST_XLATE: idx_q <= (idx_q < new_n_q) ? idx_q + CNT_W'(1) : '0;
                ST_REL: begin
                    if (idx_q >= old_n_q) idx_q <= '0;
                    else if (old_kept || ev_ready) idx_q <= idx_q + CNT_W'(1);
                end
                ST_PRESS: begin
                    if (idx_q < new_n_q && ev_ready) idx_q <= idx_q + CNT_W'(1);
                end
                ST_SYNC: begin
                    if (ev_ready) old_n_q <= new_n_q;
                end
                default: ;
            endcase
        end
    end

    // key lists, no reset needed: only entries below a count are used
    always_ff @(posedge clk) begin
        if (state_q == ST_SCAN && vld_q[idx_i] && !(fn_en_q && lk_code == FN_CODE)) begin
            new_scan_q[new_n_i] <= lk_addr[SCAN_W-1:0];
        end
        if (state_q == ST_XLATE && idx_q < new_n_q) begin
            new_code_q[idx_i] <= lk_code;
            new_addr_q[idx_i] <= lk_addr;
        end
        if (state_q == ST_SYNC && ev_ready) begin
            for (int k = 0; k < SLOTS; k++) old_code_q[k] <= new_code_q[k];
        end
    end

    // checker state: a press has been handed out for the current snapshot
    logic saw_press_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) saw_press_q <= 1'b0;
        else if (snap_valid && snap_ready) saw_press_q <= 1'b0;
        else if (ev_valid && ev_ready && ev_kind == EV_PRESS) saw_press_q <= 1'b1;
    end

    // R11: a stalled event holds still
    a_r11_event_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid && !ev_ready |=> ev_valid && $stable(ev_kind) && $stable(ev_scan) && $stable(ev_code));

    // R2: accepting a snapshot closes the input until the stream drains
    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        snap_valid && snap_ready |=> !snap_ready);

    // R8: releases precede presses
    a_r8_release_first: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid && ev_kind == EV_RELEASE |-> !saw_press_q);

    // R5: layer bit of a pressed scancode follows the function flag
    a_r5_layer_bit: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid && ev_kind == EV_PRESS |-> ev_scan[ADDR_W-1] == fn_hit_q);

    // R6: a ghosted snapshot returns to idle without an event
    a_r6_ghost_silent: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_CHECK && ghost |=> snap_ready && !ev_valid);

    // R9: accepted set never exceeds the slot count
    a_r9_set_bound: assert property (@(posedge clk) disable iff (!rst_n)
        old_n_q <= CNT_W'(SLOTS));

endmodule

// File: tb/keychg_reporter_test.sv
`timescale 1ns/1ps
module keychg_reporter_test;
    localparam logic [15:0] FN = 16'h01D0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fn_layer_en = 1'b0;
    logic        snap_valid = 1'b0;
    logic        snap_ready;
    logic        snap_empty = 1'b0;
    logic [7:0]  snap_key_vld = '0;
    logic [31:0] snap_rows = '0;
    logic [23:0] snap_cols = '0;
    logic        tbl_we = 1'b0;
    logic [7:0]  tbl_addr = '0;
    logic [15:0] tbl_data = '0;
    logic        ev_valid;
    logic        ev_ready;
    logic [1:0]  ev_kind;
    logic [7:0]  ev_scan;
    logic [15:0] ev_code;

    always #2.5 clk = ~clk;

    keychg_reporter uut (
        .clk(clk), .rst_n(rst_n), .fn_layer_en(fn_layer_en),
        .snap_valid(snap_valid), .snap_ready(snap_ready), .snap_empty(snap_empty),
        .snap_key_vld(snap_key_vld), .snap_rows(snap_rows), .snap_cols(snap_cols),
        .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
        .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_kind(ev_kind),
        .ev_scan(ev_scan), .ev_code(ev_code)
    );

    int checks = 0;
    int errors = 0;

    // vector: {empty, fn, slot bytes (slot0 lowest: bit7 valid, 6:3 row, 2:0 col), expected events}
    localparam int NV = 16;
    localparam logic [73:0] VEC [NV] = '{
        {1'b0, 1'b0, 64'h8A,               8'd2},
        {1'b0, 1'b0, 64'h9D8A,             8'd3},
        {1'b0, 1'b0, 64'h9D0000,           8'd3},
        {1'b0, 1'b0, 64'h908180,           8'd0},
        {1'b0, 1'b0, 64'h928980,           8'd5},
        {1'b0, 1'b0, 64'hA2A1A0,           8'd7},
        {1'b0, 1'b1, 64'h93BF,             8'd5},
        {1'b0, 1'b0, 64'h93BF,             8'd4},
        {1'b0, 1'b1, 64'h87B8BF,           8'd5},
        {1'b0, 1'b0, 64'hFFF6EDE4DBD2C9C0, 8'd11},
        {1'b1, 1'b0, 64'h8A,               8'd9},
        {1'b1, 1'b0, 64'h0,                8'd1},
        {1'b0, 1'b0, 64'h0A0B,             8'd1},
        {1'b0, 1'b0, 64'hA9,               8'd2},
        {1'b0, 1'b0, 64'hB4B18C89,         8'd0},
        {1'b0, 1'b0, 64'hA9,               8'd2}
    };

    logic [15:0] bench_tbl [256];
    logic [15:0] held [8];
    int          held_n = 0;

    logic [1:0]  ex_kind [32];
    logic [7:0]  ex_scan [32];
    logic [15:0] ex_code [32];
    int          ex_n;

    logic [1:0]  ob_kind [64];
    logic [7:0]  ob_scan [64];
    logic [15:0] ob_code [64];
    int          ob_n = 0;
    bit          capture = 1'b0;
    bit          bp_mode = 1'b0;

    always @(negedge clk) begin
        if (capture && ev_valid && ev_ready && ob_n < 64) begin
            ob_kind[ob_n] = ev_kind;
            ob_scan[ob_n] = ev_scan;
            ob_code[ob_n] = ev_code;
            ob_n++;
        end
    end

    initial begin
        ev_ready = 1'b1;
        forever begin
            @(posedge clk); #1;
            ev_ready = bp_mode ? ~ev_ready : 1'b1;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic add_ev(input logic [1:0] k, input logic [7:0] s, input logic [15:0] c);
        ex_kind[ex_n] = k; ex_scan[ex_n] = s; ex_code[ex_n] = c; ex_n++;
    endtask

    // expected events from the requirements
    task automatic model(input logic emp, input logic fn, input logic [7:0] vld,
                         input logic [31:0] rw, input logic [23:0] cl, output bit gh);
        logic [6:0]  sl [8];
        logic [15:0] nc [8];
        logic [7:0]  na [8];
        int n = 0;
        bit fnh = 1'b0, rs = 1'b0, cs = 1'b0, found;
        ex_n = 0;
        for (int i = 0; i < 8; i++) begin
            if (!emp && vld[i]) begin
                logic [6:0] s;
                s = {rw[4*i +: 4], cl[3*i +: 3]};
                if (fn && bench_tbl[{1'b0, s}] == FN) fnh = 1'b1;
                else begin sl[n] = s; n++; end
            end
        end
        for (int i = 0; i < n; i++)
            for (int j = i + 1; j < n; j++) begin
                if (sl[i][6:3] == sl[j][6:3]) rs = 1'b1;
                if (sl[i][2:0] == sl[j][2:0]) cs = 1'b1;
            end
        gh = (n >= 3) && rs && cs;
        if (gh) return;
        for (int k = 0; k < n; k++) begin
            na[k] = {fnh, sl[k]};
            nc[k] = bench_tbl[na[k]];
        end
        for (int h = 0; h < held_n; h++) begin
            found = 1'b0;
            for (int k = 0; k < n; k++) if (nc[k] == held[h]) found = 1'b1;
            if (!found) add_ev(2'd0, 8'h00, held[h]);
        end
        for (int k = 0; k < n; k++) add_ev(2'd1, na[k], nc[k]);
        add_ev(2'd2, 8'h00, 16'h0000);
        for (int k = 0; k < n; k++) held[k] = nc[k];
        held_n = n;
    endtask

    task automatic run_snap(input logic emp, input logic fn, input logic [63:0] slots,
                            input int exp_cnt, input string tag);
        bit gh;
        logic [7:0]  vld;
        logic [31:0] rw;
        logic [23:0] cl;
        for (int i = 0; i < 8; i++) begin
            vld[i]         = slots[8*i+7];
            rw[4*i +: 4]   = slots[8*i+3 +: 4];
            cl[3*i +: 3]   = slots[8*i +: 3];
        end
        model(emp, fn, vld, rw, cl, gh);
        if (exp_cnt >= 0) check(tag, ex_n, exp_cnt, "vector event count");
        ob_n = 0;
        capture = 1'b1;
        do begin @(posedge clk); #1; end while (!snap_ready);
        snap_valid = 1'b1; snap_empty = emp; fn_layer_en = fn;
        snap_key_vld = vld; snap_rows = rw; snap_cols = cl;
        @(posedge clk); #1;
        snap_valid = 1'b0;
        check("R2", snap_ready, 0, "ready after accept");
        if (gh) begin
            repeat (30) @(posedge clk);
            #1;
            check("R6", ob_n, 0, "ghost events");
            check("R6", snap_ready, 1, "ready after ghost");
        end else begin
            for (int c = 0; c < 150; c++) begin
                if (ob_n > 0 && ob_kind[ob_n-1] == 2'd2) break;
                @(posedge clk); #1;
            end
            check(tag, ob_n, ex_n, "event count");
            for (int k = 0; k < ex_n && k < ob_n; k++) begin
                string et;
                et = (ex_kind[k] == 2'd0) ? "R7" : (ex_kind[k] == 2'd1) ? "R8 R3" : "R9";
                check(et, ob_kind[k], ex_kind[k], "kind");
                check(et, ob_scan[k], ex_scan[k], "scan");
                check(et, ob_code[k], ex_code[k], "code");
            end
        end
        capture = 1'b0;
    endtask

    task automatic write_tbl(input logic [7:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        tbl_we = 1'b1; tbl_addr = a; tbl_data = d;
        bench_tbl[a] = d;
        @(posedge clk); #1;
        tbl_we = 1'b0;
    endtask

    function automatic string pick_tag(input logic emp, input logic fn, input logic [63:0] slots);
        logic [7:0] v;
        for (int i = 0; i < 8; i++) v[i] = slots[8*i+7];
        if (emp) return "R10";
        if (fn) return "R5";
        if (v == 8'h00) return "R12";
        return "R8 R7";
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R2 watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1", snap_ready, 1, "ready after reset");
        check("R1", ev_valid, 0, "valid after reset");

        // table: layer entries 0x1000+addr, function key at row 7 col 7
        for (int a = 0; a < 256; a++) begin
            @(posedge clk); #1;
            tbl_we   = 1'b1;
            tbl_addr = 8'(a);
            tbl_data = (a == 8'h3F) ? FN : 16'h1000 + 16'(a);
            bench_tbl[a] = tbl_data;
        end
        @(posedge clk); #1;
        tbl_we = 1'b0;

        for (int v = 0; v < NV; v++) begin
            run_snap(VEC[v][73], VEC[v][72], VEC[v][71:8], int'(VEC[v][7:0]),
                     pick_tag(VEC[v][73], VEC[v][72], VEC[v][71:8]));
        end

        // R4: rewrite one entry, then press that key
        write_tbl(8'h0A, 16'hBEEF);
        run_snap(1'b0, 1'b0, 64'h8A, 3, "R4");

        // R11: eight keys under alternating backpressure
        bp_mode = 1'b1;
        run_snap(1'b0, 1'b0, 64'hFFF6EDE4DBD2C9C0, 10, "R11");
        bp_mode = 1'b0;

        // R1: reset clears the held set but keeps the table
        run_snap(1'b0, 1'b0, 64'h8A, -1, "R1");
        @(posedge clk); #1;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        held_n = 0;
        @(negedge clk);
        check("R1", snap_ready, 1, "ready after mid reset");
        check("R1", ev_valid, 0, "valid after mid reset");
        run_snap(1'b1, 1'b0, 64'h0, 1, "R1");
        run_snap(1'b0, 1'b0, 64'h8A, 2, "R1");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule